// File: doc/BRIEF.md
# Fetch-Run Next-Address Predictor

This block guesses, in the same cycle that a fetch run starts, where the following run will begin. It does not wait for the instruction cache to return the block, for the branches in it to be found, or for their targets to be computed. As a result, instruction fetch can be steered on every cycle, even when predicted-taken branches come one after another. The start address of the current run is hashed into a small table. Each entry in the table describes one fetch block: a partial tag, one taken hint per instruction slot, and one target address per slot. The block returns the target of the first slot, in program order, that is predicted taken.

A second port receives resolved branch outcomes from execution. Each outcome writes one slot of one entry. When the entry belongs to a different run, the entry is taken over and its other hints are dropped. The table is a small fraction of the instruction cache in size, and its depth, tag width, slot count and address width are all parameters.

Top module: `fetch_run_predictor`

## Requirements
- R1: After reset no entry is valid, so every lookup reports `lk_hit`=0 and `lk_taken`=0 until an update has been made.
- R2: With the default parameters the table index is address bits [7:4] XOR bits [11:8], and the partial tag is bits [13:8]. A lookup hits only when the indexed entry is valid and its stored tag equals the tag of the lookup address.
- R3: On a hit, when several slots hold a taken hint, `lk_taken`=1 and `lk_next` is the target of the lowest-numbered taken slot. Slot k is address bits [3:2]==k, and there are four 4-byte slots in each 16-byte fetch block.
- R4: Slots numbered below the start slot of the lookup address (bits [3:2]) are ignored, even when they hold a taken hint.
- R5: On a miss, or on a hit with no eligible taken slot, `lk_taken`=0 and `lk_next` is the start of the next fetch block, ((addr>>4)+1)<<4.
- R6: An update whose tag matches a valid entry writes the target and the taken hint of slot `upd_slot` only. The other slots of that entry keep their contents.
- R7: An update that finds the indexed entry invalid, or holding another tag, makes the entry valid with the new tag. It clears every taken hint except the one in `upd_slot`, which is set to `upd_taken`.
- R8: When an update and a lookup use the same entry in the same cycle, the lookup sees the contents from before the update. The update becomes visible from the next cycle.
- R9: A lookup is answered combinationally in the cycle its address is presented, so a new address can be looked up on every cycle with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | ADDR_W | Start address of the current fetch run |
| lk_hit | output | 1 | Indexed entry is valid and its tag matches |
| lk_taken | output | 1 | An eligible slot is predicted taken |
| lk_next | output | ADDR_W | Predicted start address of the next run |
| upd_en | input | 1 | Resolved branch outcome is present |
| upd_addr | input | ADDR_W | Run start address of the resolved branch |
| upd_slot | input | SLOT_W | Slot of the resolved branch within its block |
| upd_taken | input | 1 | Resolved direction (new taken hint) |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The bench puts two runs with different tags into the same index. A design that ignored the tag, or that kept stale hints when an entry was taken over, would then redirect fetch to a target that belongs to the other run. It also fills one entry with several taken slots and looks it up from different start slots. If the priority were reversed, or slots before the start were not masked, the bench would see a later target or a branch that has already been passed. Updates are issued in the same cycle as lookups of the same entry, so a design that forwards new data would return the new target one cycle too early. Random traffic over a small address pool keeps aliasing frequent, and every result is compared against an array model held in the bench.

// File: rtl/frp_pkg.sv
package frp_pkg;
  localparam int FRP_ADDR_W = 32;
  localparam int FRP_IDX_W  = 4;
  localparam int FRP_TAG_W  = 6;
  localparam int FRP_SLOTS  = 4;
  localparam int FRP_INSN_B = 4;
endpackage

// File: rtl/fr_index.sv
module fr_index #(
  parameter int ADDR_W = frp_pkg::FRP_ADDR_W,
  parameter int IDX_W  = frp_pkg::FRP_IDX_W,
  parameter int TAG_W  = frp_pkg::FRP_TAG_W,
  parameter int SLOTS  = frp_pkg::FRP_SLOTS,
  parameter int INSN_B = frp_pkg::FRP_INSN_B,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int INSN_SH = $clog2(INSN_B),
  localparam int OFF_W = $clog2(SLOTS * INSN_B)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag,
  output logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] fall
);
  function automatic logic [IDX_W-1:0] hash_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W] ^ a[OFF_W+IDX_W +: IDX_W];
  endfunction

  function automatic logic [ADDR_W-1:0] next_block(input logic [ADDR_W-1:0] a);
    return ((a >> OFF_W) + 1'b1) << OFF_W;
  endfunction

  assign idx  = hash_of(addr);
  assign tag  = addr[OFF_W+IDX_W +: TAG_W];
  assign slot = addr[INSN_SH +: SLOT_W];
  assign fall = next_block(addr);
endmodule

// File: rtl/fr_select.sv
module fr_select #(
  parameter int ADDR_W = frp_pkg::FRP_ADDR_W,
  parameter int SLOTS  = frp_pkg::FRP_SLOTS,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SLOTS-1:0]        hint,
  input  logic [SLOTS*ADDR_W-1:0] tgts,
  input  logic [SLOT_W-1:0]       start,
  output logic [SLOTS-1:0]        grant,
  output logic                    found,
  output logic [ADDR_W-1:0]       target
);
  logic [SLOTS-1:0] eligible;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_elig
      assign eligible[g] = hint[g] && (g >= int'(start));
    end
  endgenerate

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!found && eligible[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    target = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (grant[i]) target = target | tgts[i*ADDR_W +: ADDR_W];
    end
  end

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~hint) == '0));

  // R4
  below_start_chk: assert property (@(posedge clk) disable iff (rst)
    grant != '0 |-> (grant >> start) != '0);
endmodule

// File: rtl/fr_table.sv
module fr_table #(
  parameter int ADDR_W = frp_pkg::FRP_ADDR_W,
  parameter int IDX_W  = frp_pkg::FRP_IDX_W,
  parameter int TAG_W  = frp_pkg::FRP_TAG_W,
  parameter int SLOTS  = frp_pkg::FRP_SLOTS,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [TAG_W-1:0]        rd_tag,
  output logic                    rd_hit,
  output logic [SLOTS-1:0]        rd_hint,
  output logic [SLOTS*ADDR_W-1:0] rd_tgts,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic                    wr_taken,
  input  logic [ADDR_W-1:0]       wr_tgt
);
  logic [ENTRIES-1:0]      valid_q;
  logic [TAG_W-1:0]        tag_q  [ENTRIES];
  logic [SLOTS-1:0]        hint_q [ENTRIES];
  logic [SLOTS*ADDR_W-1:0] tgt_q  [ENTRIES];

  logic wr_merge, wr_realloc;
  assign wr_merge   = wr_en && valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
  assign wr_realloc = wr_en && !wr_merge;

  assign rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_hint = hint_q[rd_idx];
  assign rd_tgts = tgt_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        hint_q[e] <= '0;
        tag_q[e]  <= '0;
        tgt_q[e]  <= '0;
      end
    end else if (wr_en) begin
      tgt_q[wr_idx][wr_slot*ADDR_W +: ADDR_W] <= wr_tgt;
      if (wr_merge) begin
        hint_q[wr_idx][wr_slot] <= wr_taken;
      end else begin
        valid_q[wr_idx] <= 1'b1;
        tag_q[wr_idx]   <= wr_tag;
        hint_q[wr_idx]  <= SLOTS'(wr_taken) << wr_slot;
      end
    end
  end

  logic              chk_merge_q, chk_realloc_q, chk_taken_q;
  logic [IDX_W-1:0]  chk_idx_q;
  logic [SLOT_W-1:0] chk_slot_q;
  logic [TAG_W-1:0]  chk_tag_q;
  always_ff @(posedge clk) begin
    chk_merge_q   <= wr_merge && !rst;
    chk_realloc_q <= wr_realloc && !rst;
    chk_idx_q     <= wr_idx;
    chk_slot_q    <= wr_slot;
    chk_taken_q   <= wr_taken;
    chk_tag_q     <= wr_tag;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> valid_q == '0);

  // R6
  merge_write_chk: assert property (@(posedge clk) disable iff (rst)
    chk_merge_q |-> hint_q[chk_idx_q][chk_slot_q] == chk_taken_q);

  // R7
  realloc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    chk_realloc_q |-> valid_q[chk_idx_q] && tag_q[chk_idx_q] == chk_tag_q &&
      $countones(hint_q[chk_idx_q]) == int'(chk_taken_q));
endmodule

// File: rtl/fetch_run_predictor.sv
module fetch_run_predictor #(
  parameter int ADDR_W = frp_pkg::FRP_ADDR_W,
  parameter int IDX_W  = frp_pkg::FRP_IDX_W,
  parameter int TAG_W  = frp_pkg::FRP_TAG_W,
  parameter int SLOTS  = frp_pkg::FRP_SLOTS,
  parameter int INSN_B = frp_pkg::FRP_INSN_B,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_next,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  logic [IDX_W-1:0]        lk_idx, up_idx;
  logic [TAG_W-1:0]        lk_tag, up_tag;
  logic [SLOT_W-1:0]       lk_slot, up_slot_unused;
  logic [ADDR_W-1:0]       lk_fall, up_fall_unused;
  logic                    tbl_hit, sel_found;
  logic [SLOTS-1:0]        tbl_hint, sel_grant;
  logic [SLOTS*ADDR_W-1:0] tbl_tgts;
  logic [ADDR_W-1:0]       sel_target;

  fr_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SLOTS(SLOTS), .INSN_B(INSN_B))
    lk_ix_i (.addr(lk_addr), .idx(lk_idx), .tag(lk_tag), .slot(lk_slot), .fall(lk_fall));

  fr_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SLOTS(SLOTS), .INSN_B(INSN_B))
    up_ix_i (.addr(upd_addr), .idx(up_idx), .tag(up_tag), .slot(up_slot_unused),
             .fall(up_fall_unused));

  fr_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SLOTS(SLOTS)) tbl_i (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(tbl_hit), .rd_hint(tbl_hint), .rd_tgts(tbl_tgts),
    .wr_en(upd_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_slot(upd_slot),
    .wr_taken(upd_taken), .wr_tgt(upd_target)
  );

  fr_select #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) sel_i (
    .clk(clk), .rst(rst), .hint(tbl_hint), .tgts(tbl_tgts), .start(lk_slot),
    .grant(sel_grant), .found(sel_found), .target(sel_target)
  );

  assign lk_hit   = tbl_hit;
  assign lk_taken = tbl_hit && sel_found;
  assign lk_next  = lk_taken ? sel_target : lk_fall;

  // R5
  fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_taken |-> lk_next == (((lk_addr >> $clog2(SLOTS*INSN_B)) + 1'b1) << $clog2(SLOTS*INSN_B)));

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> !lk_taken);
endmodule

// File: tb/fetch_run_predictor_tb_top.sv
module fetch_run_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_next;
  logic        upd_en = 1'b0;
  logic [31:0] upd_addr = '0;
  logic [1:0]  upd_slot = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  always #2 clk = ~clk;

  fetch_run_predictor dut_i (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_next(lk_next), .upd_en(upd_en), .upd_addr(upd_addr), .upd_slot(upd_slot),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit          m_val  [16];
  logic [5:0]  m_tag  [16];
  logic [3:0]  m_hint [16];
  logic [31:0] m_tgt  [16][4];

  function automatic int b_idx(input logic [31:0] a);
    return int'(a[7:4] ^ a[11:8]);
  endfunction

  function automatic logic [5:0] b_tag(input logic [31:0] a);
    return a[13:8];
  endfunction

  function automatic logic [31:0] b_fall(input logic [31:0] a);
    return {a[31:4], 4'h0} + 32'h10;
  endfunction

  task automatic expect_of(input logic [31:0] a, output bit h, output bit t,
                           output logic [31:0] n);
    int i = b_idx(a);
    h = m_val[i] && (m_tag[i] == b_tag(a));
    t = 1'b0;
    n = b_fall(a);
    if (h) begin
      for (int s = 3; s >= int'(a[3:2]); s--) begin
        if (m_hint[i][s]) begin
          t = 1'b1;
          n = m_tgt[i][s];
        end
      end
    end
  endtask

  task automatic model_update(input logic [31:0] a, input int s, input bit tk,
                              input logic [31:0] tg);
    int i = b_idx(a);
    if (!(m_val[i] && m_tag[i] == b_tag(a))) begin
      m_val[i]  = 1'b1;
      m_tag[i]  = b_tag(a);
      m_hint[i] = 4'h0;
    end
    m_hint[i][s] = tk;
    m_tgt[i][s]  = tg;
  endtask

  task automatic step(input logic [31:0] la, input bit ue, input logic [31:0] ua,
                      input int us, input bit ut, input logic [31:0] utg, input string req);
    bit eh, et;
    logic [31:0] en;
    @(negedge clk);
    lk_addr = la; upd_en = ue; upd_addr = ua; upd_slot = 2'(us);
    upd_taken = ut; upd_target = utg;
    #1;
    expect_of(la, eh, et, en);
    checks++;
    if (lk_hit !== eh || lk_taken !== et || lk_next !== en) begin
      fails++;
      $display("FAIL %s addr=%h actual hit=%b taken=%b next=%h expected hit=%b taken=%b next=%h",
               req, la, lk_hit, lk_taken, lk_next, eh, et, en);
    end
    @(posedge clk);
    if (ue) model_update(ua, us, ut, utg);
  endtask

  task automatic look(input logic [31:0] la, input string req);
    step(la, 1'b0, 32'h0, 0, 1'b0, 32'h0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [31:0] RA = 32'h0000_0100;
  localparam logic [31:0] RB = 32'h0000_0010;

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 16; i++) begin
      m_val[i] = 0; m_tag[i] = '0; m_hint[i] = '0;
      for (int s = 0; s < 4; s++) m_tgt[i][s] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    look(RA, "R1 reset miss");
    look(RB + 32'h4, "R1 reset miss");
    step(RA, 1'b1, RA, 2, 1'b1, 32'h0000_4000, "R8 old contents on same-cycle update");
    look(RA, "R3 single taken slot");
    step(RA, 1'b1, RA, 1, 1'b1, 32'h0000_5000, "R8 old target during update");
    look(RA, "R3 first taken slot wins");
    step(RA + 32'h4, 1'b1, RA, 0, 1'b0, 32'h0000_6000, "R9 back-to-back lookup");
    look(RA, "R6 not-taken slot leaves others");
    look(RA + 32'h8, "R4 earlier slots ignored");
    look(RA + 32'hC, "R5 hit without eligible taken slot");
    look(RA + 32'h1000, "R2 wrong partial tag misses");
    step(RB, 1'b1, RB, 3, 1'b1, 32'h0000_7000, "R2 alias before realloc");
    look(RA, "R7 alias evicted other run");
    look(RB, "R7 realloc entry hit");
    look(RB + 32'hC, "R7 realloc slot3");
    step(RA, 1'b1, RA, 3, 1'b1, 32'h0000_8000, "R8 same-cycle realloc");
    look(RA, "R7 old slots cleared after realloc");
    look(RB, "R2 alias now misses");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, u, tg;
      a  = {$urandom() % 4, 10'h0, 2'($urandom()), 2'($urandom()), 2'($urandom()), 2'b00} |
           (32'($urandom() % 4) << 8);
      u  = {18'h0, 4'(2 * ($urandom() % 2)), 4'($urandom() % 4), 2'($urandom()), 2'b00};
      u  = u | (32'($urandom() % 4) << 8);
      tg = {$urandom()} & 32'hFFFF_FFFC;
      step(a, ($urandom() % 3) != 0, ($urandom() % 4 == 0) ? a : u, int'($urandom() % 4),
           ($urandom() % 3) != 0, tg, "R3/R5 random vs model");
    end

    finish_run();
  end
endmodule